// File: doc/BRIEF.md
# Pad Ownership Handover Sequencer

This block hands the pads of a serial audio link back and forth between the always-on glue logic and the link master controller. A single-cycle command chooses one of three sequences: a full bring-up, a glue-to-master handover, or a master-to-glue handover. The block then steps a 16-bit pad control word through a fixed ordering of bit changes. Each step is applied on its own and is held for a settle interval before the next step is applied.

The order of the steps depends on the direction of the handover, so the glue logic never drives against the master. The bring-up sequence starts from an all-zero pad word. It parks the pads in a safe driven state, then runs the glue-to-master ordering by itself, and ends by programming a second control word that sets idle drive behaviour. A busy level and a one-cycle done pulse tell the caller when the sequence is complete. A registered flag reports which side owns the pads.

Top module: `pad_handover_seq`

## Requirements
- R1: While reset is asserted and after it is released, pad_ctrl and link_ctrl are 16'h0000, and busy, done, cmd_err and master_owns are 0.
- R2: Pad word bits are: 0 bus keeper enable, 1 wake pull-down disable, 2 data out, 3 data out enable, 4 master interface select, 5 clock out enable, and all other bits stay 0. The init command (cmd_op 2'd1) first loads 16'h0001, then sets bit 1, then bit 2, then bit 3, one step at a time (16'h0001, 16'h0003, 16'h0007, 16'h000F).
- R3: Glue-to-master (cmd_op 2'd2, and also the continuation of init) applies four steps in this order: clear bit 3, clear bit 2, set bit 4, then clear bits 0 and 5 together.
- R4: Master-to-glue (cmd_op 2'd3) applies two steps in this order: set bits 0 and 5 together, then clear bit 4.
- R5: Every step is held unchanged for exactly SETTLE_CYC = ceil(CLK_MHZ*SETTLE_NS/1000) cycles, which lies between 10 us and 15 us of clock time. The next step, or completion, happens on the edge after that.
- R6: As its final step, after the glue-to-master part, init writes link_ctrl with bits [1:0] = 2'b01 (idle output mode 1), bit 2 set (active qualifier enable) and bit 3 set (drive strength), which gives 16'h000D from reset. The pad word is unchanged in that step. The two handover commands leave link_ctrl unchanged.
- R7: busy rises on the edge that accepts a command and falls on the edge where the last interval expires. done is high for exactly the one cycle after that edge.
- R8: A command that arrives while busy is ignored: the running sequence carries on with unchanged words and timing. cmd_err pulses high for one cycle after that edge.
- R9: master_owns becomes 1 when init or glue-to-master completes and becomes 0 when master-to-glue completes. It changes at no other time.
- R10: A command with cmd_op 2'd0 while idle is ignored: busy stays 0, there is no error, and the pad word is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled on the rising edge |
| cmd_op | input | 2 | 1 init, 2 glue-to-master, 3 master-to-glue, 0 no operation |
| pad_ctrl | output | 16 | Pad control word |
| link_ctrl | output | 16 | Idle/drive control word written at the end of init |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| cmd_err | output | 1 | One-cycle pulse for a command refused while busy |
| master_owns | output | 1 | The master controller owns the pads |

## Verification
The assertions take cmd_op as meaningful only in a cycle where cmd_valid is high. They assume reset is applied before the first command. The stimulus drives every command for exactly one cycle and sets it up on the falling edge. It waits for done before it starts the next sequence. It places the single overlapping command in the middle of a settle interval, so the refusal can be seen apart from a step boundary. Pad and link words are sampled at the start and at the end of every interval. This pins down both the ordering and the exact hold length.

// File: rtl/pad_hs_pkg.sv
package pad_hs_pkg;

  typedef enum logic [1:0] {
    HS_NOP     = 2'd0,
    HS_INIT    = 2'd1,
    HS_TO_MST  = 2'd2,
    HS_TO_GLUE = 2'd3
  } hs_op_e;

  localparam int WORD_W = 16;
  localparam int IDX_W  = 4;

  // pad word bit positions
  localparam int B_KEEP  = 0;
  localparam int B_PDD   = 1;
  localparam int B_DO    = 2;
  localparam int B_DOE   = 3;
  localparam int B_MIF   = 4;
  localparam int B_CLKOE = 5;

  // unified step table indices
  localparam logic [IDX_W-1:0] S_INIT_FIRST = 4'd0;
  localparam logic [IDX_W-1:0] S_G2M_FIRST  = 4'd4;
  localparam logic [IDX_W-1:0] S_G2M_LAST   = 4'd7;
  localparam logic [IDX_W-1:0] S_LINK_WR    = 4'd8;
  localparam logic [IDX_W-1:0] S_M2G_FIRST  = 4'd9;
  localparam logic [IDX_W-1:0] S_M2G_LAST   = 4'd10;

  // link control word fields
  localparam logic [WORD_W-1:0] LINK_FIELD_MASK = 16'h000F;
  localparam logic [WORD_W-1:0] LINK_FIELD_VAL  = 16'h000D;

endpackage

// File: rtl/pad_hs_settle_timer.sv
module pad_hs_settle_timer #(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    expire = run_q && (cnt_q == '0);
    cnt_d  = cnt_q;
    run_d  = run_q;
    if (load) begin
      cnt_d = RELOAD;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  generate
    if (SETTLE_CYC >= 2) begin : g_chk
      assert_no_early_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> !expire);
    end
  endgenerate

endmodule

// File: rtl/pad_hs_step_dec.sv
module pad_hs_step_dec
  import pad_hs_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] pad_cur,
  input  logic [WORD_W-1:0] link_cur,
  output logic [WORD_W-1:0] pad_nxt,
  output logic [WORD_W-1:0] link_nxt
);
  localparam logic [WORD_W-1:0] M_KEEP  = WORD_W'(1) << B_KEEP;
  localparam logic [WORD_W-1:0] M_PDD   = WORD_W'(1) << B_PDD;
  localparam logic [WORD_W-1:0] M_DO    = WORD_W'(1) << B_DO;
  localparam logic [WORD_W-1:0] M_DOE   = WORD_W'(1) << B_DOE;
  localparam logic [WORD_W-1:0] M_MIF   = WORD_W'(1) << B_MIF;
  localparam logic [WORD_W-1:0] M_CLKOE = WORD_W'(1) << B_CLKOE;

  always_comb begin
    pad_nxt  = pad_cur;
    link_nxt = link_cur;
    case (idx)
      4'd0:    pad_nxt = M_KEEP;
      4'd1:    pad_nxt = pad_cur | M_PDD;
      4'd2:    pad_nxt = pad_cur | M_DO;
      4'd3:    pad_nxt = pad_cur | M_DOE;
      4'd4:    pad_nxt = pad_cur & ~M_DOE;
      4'd5:    pad_nxt = pad_cur & ~M_DO;
      4'd6:    pad_nxt = pad_cur | M_MIF;
      4'd7:    pad_nxt = pad_cur & ~(M_KEEP | M_CLKOE);
      4'd8:    link_nxt = (link_cur & ~LINK_FIELD_MASK) | LINK_FIELD_VAL;
      4'd9:    pad_nxt = pad_cur | M_KEEP | M_CLKOE;
      4'd10:   pad_nxt = pad_cur & ~M_MIF;
      default: pad_nxt = pad_cur;
    endcase
  end

endmodule

// File: rtl/pad_handover_seq.sv
module pad_handover_seq
  import pad_hs_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_NS = 12500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  output logic [15:0] pad_ctrl,
  output logic [15:0] link_ctrl,
  output logic        busy,
  output logic        done,
  output logic        cmd_err,
  output logic        master_owns
);
  localparam int SETTLE_CYC = (CLK_MHZ * SETTLE_NS + 999) / 1000;

  hs_op_e              op_q, op_d;
  logic [IDX_W-1:0]    idx_q, idx_d, idx_sel, start_idx;
  logic [WORD_W-1:0]   pad_q, pad_d, link_q, link_d, pad_step, link_step;
  logic                busy_q, busy_d, done_q, done_d, err_q, err_d, own_q, own_d;
  logic                accept, advance, finish, last_step, tmr_load, tmr_expire;

  pad_hs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .expire (tmr_expire)
  );

  pad_hs_step_dec u_dec (
    .idx      (idx_sel),
    .pad_cur  (pad_q),
    .link_cur (link_q),
    .pad_nxt  (pad_step),
    .link_nxt (link_step)
  );

  always_comb begin
    case (hs_op_e'(cmd_op))
      HS_INIT:    start_idx = S_INIT_FIRST;
      HS_TO_MST:  start_idx = S_G2M_FIRST;
      HS_TO_GLUE: start_idx = S_M2G_FIRST;
      default:    start_idx = S_INIT_FIRST;
    endcase
  end

  always_comb begin
    last_step = (idx_q == S_LINK_WR) || (idx_q == S_M2G_LAST) ||
                ((op_q == HS_TO_MST) && (idx_q == S_G2M_LAST));
    accept    = !busy_q && cmd_valid && (hs_op_e'(cmd_op) != HS_NOP);
    finish    = busy_q && tmr_expire && last_step;
    advance   = busy_q && tmr_expire && !last_step;
    idx_sel   = accept ? start_idx : IDX_W'(idx_q + 1'b1);
    tmr_load  = accept || advance;
  end

  always_comb begin
    op_d   = op_q;
    idx_d  = idx_q;
    pad_d  = pad_q;
    link_d = link_q;
    busy_d = busy_q;
    own_d  = own_q;
    done_d = finish;
    err_d  = busy_q && cmd_valid;
    if (accept) begin
      op_d   = hs_op_e'(cmd_op);
      idx_d  = start_idx;
      pad_d  = pad_step;
      link_d = link_step;
      busy_d = 1'b1;
    end else if (advance) begin
      idx_d  = idx_sel;
      pad_d  = pad_step;
      link_d = link_step;
    end else if (finish) begin
      busy_d = 1'b0;
      own_d  = (op_q != HS_TO_GLUE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= HS_NOP;
      idx_q  <= '0;
      pad_q  <= '0;
      link_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      own_q  <= 1'b0;
    end else begin
      op_q   <= op_d;
      idx_q  <= idx_d;
      pad_q  <= pad_d;
      link_q <= link_d;
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
      own_q  <= own_d;
    end
  end

  assign pad_ctrl    = pad_q;
  assign link_ctrl   = link_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign cmd_err     = err_q;
  assign master_owns = own_q;

  assert_step_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_ctrl) |-> $past(tmr_expire || (cmd_valid && !busy)));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_err_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(busy));
  assert_owner_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(master_owns) |-> done);

endmodule

// File: tb/pad_handover_seq_tb.sv
module pad_handover_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ    = 8;
  localparam int NS     = 12500;
  localparam int SETTLE = (MHZ * NS + 999) / 1000;

  logic clk, rst_n, cmd_valid;
  logic [1:0] cmd_op;
  logic [15:0] pad_ctrl, link_ctrl;
  logic busy, done, cmd_err, master_owns;

  typedef struct { logic [15:0] pad; logic [15:0] link; string req; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  bit mon_go = 0, mon_busy = 0, reported = 0;

  pad_handover_seq #(.CLK_MHZ(MHZ), .SETTLE_NS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pad_ctrl(pad_ctrl), .link_ctrl(link_ctrl), .busy(busy), .done(done),
    .cmd_err(cmd_err), .master_owns(master_owns));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic push(logic [15:0] p, logic [15:0] l, string r);
    exp_t e;
    e.pad = p; e.link = l; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic send(logic [1:0] op);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  // monitor: pops expected step words and compares them over each interval
  initial begin
    forever begin
      wait (mon_go);
      mon_go = 0;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(pad_ctrl == e.pad, e.req, pad_ctrl, e.pad);
        check(link_ctrl == e.link, e.req, link_ctrl, e.link);
        check(busy == 1'b1, "R7", busy, 1);
        repeat (SETTLE - 1) @(negedge clk);
        check(pad_ctrl == e.pad && link_ctrl == e.link, "R5", pad_ctrl, e.pad);
        @(negedge clk);
      end
      check(done == 1'b1 && busy == 1'b0, "R7", {done, busy}, 2'b10);
      @(negedge clk);
      check(done == 1'b0, "R7", done, 0);
      mon_busy = 0;
    end
  end

  task automatic run(logic [1:0] op);
    send(op);
    mon_busy = 1;
    mon_go = 1;
    wait (!mon_busy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_op = 0;
    repeat (3) @(negedge clk);
    check(pad_ctrl == 0 && link_ctrl == 0 && !busy && !done && !cmd_err && !master_owns,
          "R1", {pad_ctrl, link_ctrl}, 0);
    rst_n = 1;
    @(negedge clk);
    check(pad_ctrl == 0 && !busy && !master_owns, "R1", pad_ctrl, 0);

    // R10: no-operation command
    send(2'd0);
    @(negedge clk);
    check(!busy && !cmd_err && pad_ctrl == 0, "R10", {busy, cmd_err, pad_ctrl}, 0);

    // init: R2 prep, R3 handover part, R6 link write
    push(16'h0001, 16'h0000, "R2");
    push(16'h0003, 16'h0000, "R2");
    push(16'h0007, 16'h0000, "R2");
    push(16'h000F, 16'h0000, "R2");
    push(16'h0007, 16'h0000, "R3");
    push(16'h0003, 16'h0000, "R3");
    push(16'h0013, 16'h0000, "R3");
    push(16'h0012, 16'h0000, "R3");
    push(16'h0012, 16'h000D, "R6");
    run(2'd1);
    check(master_owns == 1'b1, "R9", master_owns, 1);

    // master-to-glue: R4
    push(16'h0033, 16'h000D, "R4");
    push(16'h0023, 16'h000D, "R4");
    run(2'd3);
    check(master_owns == 1'b0, "R9", master_owns, 0);
    check(link_ctrl == 16'h000D, "R6", link_ctrl, 16'h000D);

    // glue-to-master from the glue-owned state, with a refused command mid-interval: R3, R8
    push(16'h0023, 16'h000D, "R3");
    push(16'h0023, 16'h000D, "R3");
    push(16'h0033, 16'h000D, "R8");
    push(16'h0012, 16'h000D, "R8");
    fork
      run(2'd2);
      begin
        repeat (SETTLE + SETTLE / 2) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
        check(cmd_err == 1'b1, "R8", cmd_err, 1);
        @(negedge clk);
        check(cmd_err == 1'b0, "R8", cmd_err, 0);
      end
    join
    check(master_owns == 1'b1, "R9", master_owns, 1);
    check(link_ctrl == 16'h000D, "R6", link_ctrl, 16'h000D);

    repeat (5) @(negedge clk);
    check(!busy && pad_ctrl == 16'h0012, "R7", {busy, pad_ctrl}, 16'h0012);
    report();
  end

endmodule